// File: doc/BRIEF.md
# Dual-Clock FIFO Controller with Selectable Read Mode

This block is a first-in first-out buffer between two clock domains. A writer pushes words on its own clock. A reader pulls them on a separate clock. The words sit in an internal register-file RAM. Each side keeps a binary pointer and a gray-coded copy of it. The gray copy crosses into the other domain through a two-stage synchroniser, so each status flag reacts a fixed number of edges after the event on the far side.

The read mode is fixed while the master reset is held.

- **Explicit mode:** the output register loads only when it is asked to. The read-side flag means "empty".
- **Fall-through mode:** the oldest word moves into the output register by itself. The read-side flag then means "no valid word at the output". A read consumes that word and lets the next one fall through.

A read chip select only decides whether the output is being driven. It never influences the flags or the fall-through transfer. Output drive is given as an enable signal, not a three-state bus.

Two threshold flags warn of a nearly empty or nearly full buffer. Both use one offset, chosen from four presets during reset.

Top module: `dcfifo_ctrl`

## Requirements
- R1: In explicit mode (`fwft_sel`=0 at reset), `rdata` takes the next stored word only on a `rclk` rising edge where `ren_n`=0, `rcs_n`=0 and the buffer is not empty. On every other edge `rdata` keeps its value.
- R2: In explicit mode, `rd_flag`=1 means empty. It rises on the edge that reads the last visible word. While it is 1, read requests change neither `rdata` nor the read pointer.
- R3: `wr_flag`=1 when the RAM holds 2^AW words. While it is 1, write requests are dropped and no data is stored.
- R4: A write becomes visible to the read-side status exactly two `rclk` edges after the `wclk` edge that stored it. A read frees space in the write-side status exactly two `wclk` edges after the `rclk` edge that removed it.
- R5: In fall-through mode (`fwft_sel`=1 at reset), a word written into an empty buffer appears on `rdata`, with `rd_flag` going to 0, on the third `rclk` edge after the write. This happens whatever the levels of `ren_n` and `rcs_n`.
- R6: In fall-through mode, an edge with `ren_n`=0 and `rcs_n`=0 while `rd_flag`=0 consumes the output word. If no further word is visible, `rd_flag` goes to 1 on that edge. Later read requests are ignored until a new word falls through.
- R7: `rcs_n` never changes any flag or the fall-through transfer. After reset, `rd_drive` equals `!oe_n` ANDed with the value of `!rcs_n` sampled at the latest `rclk` edge.
- R8: A write needs `wen_n`=0 and `wcs_n`=0 on the same `wclk` edge. With `wcs_n`=1 nothing is stored.
- R9: `off_sel`, held during reset, picks the offset: 0→7, 1→31, 2→63, 3→127 words.
  - `almost_empty`=1 when the words visible to the reader (plus the output word in fall-through mode) are at or below the offset.
  - `almost_full`=1 when the free RAM entries seen by the writer are at or below the offset.
- R10: While `mrst_n`=0, `rd_drive` follows `!oe_n` only, whatever `rcs_n` does. The flags read `rd_flag`=1, `wr_flag`=0, `almost_empty`=1 and `almost_full`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| fwft_sel | input | 1 | Read mode select sampled in reset: 1 fall-through, 0 explicit |
| off_sel | input | 2 | Threshold preset select sampled in reset |
| wclk | input | 1 | Write clock |
| wen_n | input | 1 | Write enable, active low |
| wcs_n | input | 1 | Write chip select, active low |
| wdata | input | DW | Write data |
| rclk | input | 1 | Read clock |
| ren_n | input | 1 | Read enable, active low |
| rcs_n | input | 1 | Read chip select, active low, gates output drive only |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| rdata | output | DW | Output register contents |
| rd_drive | output | 1 | 1 when the output data would be driven |
| rd_flag | output | 1 | Explicit mode: empty. Fall-through mode: no valid output word |
| wr_flag | output | 1 | RAM full, writes blocked |
| almost_empty | output | 1 | Occupancy at or below the offset |
| almost_full | output | 1 | Free space at or below the offset |

## Verification
The embedded properties assume that `fwft_sel` and `off_sel` stay steady for the whole reset interval. They also assume that each control input is synchronous to its own clock, so every sampled level is a settled value. The stimulus changes inputs only two nanoseconds after a rising edge and holds the configuration pins constant from reset entry until release. Both clocks come from one source, so the two-edge crossing latency can be predicted exactly for every cycle.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef enum logic {
    RD_EXPLICIT = 1'b0,
    RD_FALLTHRU = 1'b1
  } rd_mode_e;

  // Threshold preset shared by both almost flags.
  function automatic logic [7:0] thresh_for(input logic [1:0] sel);
    logic [7:0] val;
    case (sel)
      2'd0:    val = 8'd7;
      2'd1:    val = 8'd31;
      2'd2:    val = 8'd63;
      default: val = 8'd127;
    endcase
    return val;
  endfunction

endpackage

// File: rtl/dcf_ptr_sync.sv
// Two-stage synchroniser for a gray pointer, then gray-to-binary conversion.
module dcf_ptr_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);

  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin_o[i] = ^s2_q[W-1:i];
  end

endmodule

// File: rtl/dcf_ram.sv
// Register-file storage: synchronous write, combinational read.
module dcf_ram #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic [1:0]    off_sel,
  input  logic          wen_n,
  input  logic          wcs_n,
  input  logic [AW:0]   rgray_i,
  output logic [AW:0]   wgray_o,
  output logic [AW-1:0] waddr,
  output logic          we,
  output logic          full,
  output logic          afull
);

  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

  logic [1:0]    rst_pipe;
  logic          rst_s;
  logic [PW-1:0] off_q;
  logic [PW-1:0] rq_bin;
  logic [PW-1:0] wbin_q, wbin_d;
  logic [PW-1:0] wgray_q, wgray_d;
  logic [PW-1:0] used, room;

  // Reset: asserted asynchronously, released on the second clock edge.
  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // Preset captured while the domain is still in reset.
  always_ff @(posedge clk) begin
    if (!rst_s) off_q <= PW'(thresh_for(off_sel));
  end

  dcf_ptr_sync #(.W(PW)) u_rsync (
    .clk   (clk),
    .rst_n (rst_s),
    .gray_i(rgray_i),
    .bin_o (rq_bin)
  );

  always_comb begin
    used   = wbin_q - rq_bin;
    room   = DEPTH_P - used;
    full   = used[AW];
    afull  = (room <= off_q);
    we     = !wen_n && !wcs_n && !full;
    wbin_d = wbin_q + 1'b1;
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (we) begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  assign wgray_o = wgray_q;
  assign waddr   = wbin_q[AW-1:0];

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_s)
    used <= DEPTH_P);

  assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_s)
    full |=> $stable(wbin_q));

  assert_wcs_blocks_R8: assert property (@(posedge clk) disable iff (!rst_s)
    wcs_n |=> $stable(wbin_q));

  assert_gray_step_R4: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(wgray_q ^ $past(wgray_q)));

endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          fwft_sel,
  input  logic [1:0]    off_sel,
  input  logic          ren_n,
  input  logic          rcs_n,
  input  logic          oe_n,
  input  logic [AW:0]   wgray_i,
  input  logic [DW-1:0] ram_q,
  output logic [AW:0]   rgray_o,
  output logic [AW-1:0] raddr,
  output logic [DW-1:0] q_o,
  output logic          rd_flag,
  output logic          aempty,
  output logic          drive
);

  localparam int PW = AW + 1;

  logic [1:0]    rst_pipe;
  logic          rst_s;
  rd_mode_e      mode_q;
  logic [PW-1:0] off_q;
  logic [PW-1:0] wq_bin;
  logic [PW-1:0] rbin_q, rbin_d;
  logic [PW-1:0] rgray_q, rgray_d;
  logic [DW-1:0] q_q;
  logic          ov_q, ov_d;
  logic          drv_q, drv_d;
  logic          take_req, ram_empty, consume, load;
  logic [PW-1:0] used_ram;
  logic [PW:0]   occ;

  // Reset: asserted asynchronously, released on the second clock edge.
  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // Mode and preset captured while the domain is still in reset.
  always_ff @(posedge clk) begin
    if (!rst_s) begin
      mode_q <= rd_mode_e'(fwft_sel);
      off_q  <= PW'(thresh_for(off_sel));
    end
  end

  dcf_ptr_sync #(.W(PW)) u_wsync (
    .clk   (clk),
    .rst_n (rst_s),
    .gray_i(wgray_i),
    .bin_o (wq_bin)
  );

  always_comb begin
    take_req  = !ren_n && !rcs_n;
    ram_empty = (wq_bin == rbin_q);
    consume   = 1'b0;
    ov_d      = ov_q;
    if (mode_q == RD_FALLTHRU) begin
      // Output word leaves on a true read; a visible word refills it
      // whenever the register is empty, without any request.
      consume = take_req && ov_q;
      load    = (!ov_q || consume) && !ram_empty;
      if (load)         ov_d = 1'b1;
      else if (consume) ov_d = 1'b0;
    end else begin
      load = take_req && !ram_empty;
    end
    rbin_d   = rbin_q + 1'b1;
    rgray_d  = rbin_d ^ (rbin_d >> 1);
    drv_d    = !rcs_n;
    used_ram = wq_bin - rbin_q;
    occ      = {1'b0, used_ram} + {{PW{1'b0}}, (mode_q == RD_FALLTHRU) && ov_q};
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      q_q     <= '0;
      ov_q    <= 1'b0;
      drv_q   <= 1'b1;
    end else begin
      if (load) begin
        rbin_q  <= rbin_d;
        rgray_q <= rgray_d;
        q_q     <= ram_q;
      end
      ov_q  <= ov_d;
      drv_q <= drv_d;
    end
  end

  assign rgray_o = rgray_q;
  assign raddr   = rbin_q[AW-1:0];
  assign q_o     = q_q;
  assign rd_flag = (mode_q == RD_FALLTHRU) ? !ov_q : ram_empty;
  assign aempty  = (occ <= {1'b0, off_q});
  assign drive   = !oe_n && drv_q;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_q == RD_EXPLICIT && (ren_n || rcs_n)) |=> $stable(q_o));

  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_q == RD_EXPLICIT && rd_flag) |=> $stable(rbin_q));

  assert_fall_through_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_q == RD_FALLTHRU && rd_flag && wq_bin != rbin_q) |=> !rd_flag);

  assert_last_read_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_q == RD_FALLTHRU && !rd_flag && !ren_n && !rcs_n && wq_bin == rbin_q)
      |=> rd_flag);

  assert_drive_follow_R7: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> (drive == (!oe_n && !$past(rcs_n))));

  assert_gray_step_R4: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(rgray_q ^ $past(rgray_q)));

endmodule

// File: rtl/dcfifo_ctrl.sv
module dcfifo_ctrl #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          mrst_n,
  input  logic          fwft_sel,
  input  logic [1:0]    off_sel,
  input  logic          wclk,
  input  logic          wen_n,
  input  logic          wcs_n,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          ren_n,
  input  logic          rcs_n,
  input  logic          oe_n,
  output logic [DW-1:0] rdata,
  output logic          rd_drive,
  output logic          rd_flag,
  output logic          wr_flag,
  output logic          almost_empty,
  output logic          almost_full
);

  logic [AW:0]   wgray, rgray;
  logic [AW-1:0] waddr, raddr;
  logic          we;
  logic [DW-1:0] ram_q;

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk (wclk),
    .we   (we),
    .waddr(waddr),
    .wdata(wdata),
    .raddr(raddr),
    .rdata(ram_q)
  );

  dcf_wr_side #(.AW(AW)) u_wr (
    .clk    (wclk),
    .mrst_n (mrst_n),
    .off_sel(off_sel),
    .wen_n  (wen_n),
    .wcs_n  (wcs_n),
    .rgray_i(rgray),
    .wgray_o(wgray),
    .waddr  (waddr),
    .we     (we),
    .full   (wr_flag),
    .afull  (almost_full)
  );

  dcf_rd_side #(.DW(DW), .AW(AW)) u_rd (
    .clk     (rclk),
    .mrst_n  (mrst_n),
    .fwft_sel(fwft_sel),
    .off_sel (off_sel),
    .ren_n   (ren_n),
    .rcs_n   (rcs_n),
    .oe_n    (oe_n),
    .wgray_i (wgray),
    .ram_q   (ram_q),
    .rgray_o (rgray),
    .raddr   (raddr),
    .q_o     (rdata),
    .rd_flag (rd_flag),
    .aempty  (almost_empty),
    .drive   (rd_drive)
  );

endmodule

// File: tb/test_dcfifo_ctrl.sv
module test_dcfifo_ctrl;

  localparam int DW    = 16;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          mrst_n, fwft_sel, wen_n, wcs_n, ren_n, rcs_n, oe_n;
  logic [1:0]    off_sel;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          rd_drive, rd_flag, wr_flag, almost_empty, almost_full;

  int checks = 0;
  int fails  = 0;

  // Reference state, built from the requirements.
  int            W, R, wq1, wq2, rq1, rq2, offm;
  bit            fw, ov, drvm;
  logic [DW-1:0] qm;
  logic [DW-1:0] mref [DEPTH];

  dcfifo_ctrl #(.DW(DW), .AW(AW)) i_dcfifo_ctrl (
    .mrst_n      (mrst_n),
    .fwft_sel    (fwft_sel),
    .off_sel     (off_sel),
    .wclk        (clk),
    .wen_n       (wen_n),
    .wcs_n       (wcs_n),
    .wdata       (wdata),
    .rclk        (clk),
    .ren_n       (ren_n),
    .rcs_n       (rcs_n),
    .oe_n        (oe_n),
    .rdata       (rdata),
    .rd_drive    (rd_drive),
    .rd_flag     (rd_flag),
    .wr_flag     (wr_flag),
    .almost_empty(almost_empty),
    .almost_full (almost_full)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int thresh(input int sel);
    case (sel)
      0: return 7;
      1: return 31;
      2: return 63;
      default: return 127;
    endcase
  endfunction

  // One clock edge: predict from pre-edge inputs, then compare every output.
  task automatic step();
    int wpre, rpre;
    bit full_m, wr, ram_empty, take, consume, ld;
    wpre      = W;
    rpre      = R;
    full_m    = (W - rq2) == DEPTH;
    wr        = !wen_n && !wcs_n && !full_m;
    ram_empty = (R == wq2);
    take      = !ren_n && !rcs_n;
    if (fw) begin
      consume = take && ov;
      ld      = (!ov || consume) && !ram_empty;
    end else begin
      consume = 1'b0;
      ld      = take && !ram_empty;
    end
    if (ld) begin
      qm = mref[R % DEPTH];
      R++;
    end
    if (fw) begin
      if (ld) ov = 1'b1;
      else if (consume) ov = 1'b0;
    end
    if (wr) begin
      mref[W % DEPTH] = wdata;
      W++;
    end
    wq2 = wq1; wq1 = wpre;
    rq2 = rq1; rq1 = rpre;
    drvm = !rcs_n;
    @(posedge clk);
    #2;
    chk(fw ? "R6" : "R2", "rd_flag", rd_flag, fw ? !ov : (R == wq2));
    chk("R3", "wr_flag", wr_flag, (W - rq2) == DEPTH);
    chk("R9", "almost_empty", almost_empty,
        ((wq2 - R) + ((fw && ov) ? 1 : 0)) <= offm);
    chk("R9", "almost_full", almost_full, (DEPTH - (W - rq2)) <= offm);
    chk(fw ? "R5" : "R1", "rdata", rdata, qm);
    chk("R7", "rd_drive", rd_drive, !oe_n && drvm);
  endtask

  task automatic do_reset(input bit mode, input int sel);
    mrst_n = 1'b0; fwft_sel = mode; off_sel = 2'(sel);
    wen_n = 1'b1; wcs_n = 1'b0; ren_n = 1'b1; rcs_n = 1'b1; oe_n = 1'b0;
    wdata = '0;
    repeat (4) @(posedge clk);
    #2;
    // R10: reset state and drive under output enable only
    chk("R10", "rd_drive in reset, oe low", rd_drive, 1'b1);
    chk("R10", "rd_flag in reset", rd_flag, 1'b1);
    chk("R10", "wr_flag in reset", wr_flag, 1'b0);
    chk("R10", "almost_empty in reset", almost_empty, 1'b1);
    chk("R10", "almost_full in reset", almost_full, 1'b0);
    oe_n = 1'b1;
    #1;
    chk("R10", "rd_drive in reset, oe high", rd_drive, 1'b0);
    @(posedge clk);
    #2;
    chk("R10", "rd_drive in reset after edge", rd_drive, 1'b0);
    oe_n   = 1'b0;
    rcs_n  = 1'b0;
    mrst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    W = 0; R = 0; wq1 = 0; wq2 = 0; rq1 = 0; rq2 = 0;
    ov = 1'b0; drvm = 1'b1; qm = '0; fw = mode; offm = thresh(sel);
  endtask

  task automatic directed();
    logic [DW-1:0] first;
    first = 16'hC3A5 ^ DW'(offm);
    // R4 / R5 latency of a single write into an empty buffer
    wen_n = 1'b0; wdata = first; ren_n = 1'b1; rcs_n = fw ? 1'b1 : 1'b0;
    step();
    wen_n = 1'b1;
    step();
    chk("R4", "rd_flag one edge after write", rd_flag, 1'b1);
    step();
    if (!fw) chk("R4", "rd_flag two edges after write", rd_flag, 1'b0);
    else     chk("R5", "no fall-through at second edge", rd_flag, 1'b1);
    step();
    if (fw) begin
      chk("R5", "word fell through at third edge", rdata, first);
      chk("R7", "drive off while rcs high", rd_drive, 1'b0);
      rcs_n = 1'b0;
      step();
      chk("R7", "drive on after rcs low", rd_drive, 1'b1);
      ren_n = 1'b0;
      step();
      chk("R6", "last word consumed", rd_flag, 1'b1);
      step();
      chk("R6", "read ignored while not ready", rdata, first);
    end else begin
      chk("R1", "no output without request", rdata, 16'h0000);
      ren_n = 1'b0;
      step();
      chk("R1", "explicit read", rdata, first);
      step();
      chk("R2", "empty after last read", rd_flag, 1'b1);
      chk("R2", "read ignored while empty", rdata, first);
    end
    ren_n = 1'b1;
    // R8: chip select high blocks writes
    wcs_n = 1'b1; wen_n = 1'b0; wdata = 16'hDEAD;
    repeat (6) step();
    wcs_n = 1'b0; wen_n = 1'b1;
    repeat (3) step();
    chk("R8", "nothing stored with wcs high", rd_flag, 1'b1);
    // R3: overfill
    wen_n = 1'b0;
    for (int i = 0; i < DEPTH + 8; i++) begin
      wdata = DW'($urandom);
      step();
    end
    chk("R3", "full after overfill", wr_flag, 1'b1);
    wen_n = 1'b1;
    ren_n = 1'b0; rcs_n = 1'b0;
    for (int i = 0; i < DEPTH + 10; i++) step();
    chk(fw ? "R6" : "R2", "drained", rd_flag, 1'b1);
    ren_n = 1'b1;
  endtask

  task automatic random_run(input int n);
    int wp, rp;
    for (int i = 0; i < n; i++) begin
      case ((i * 3) / n)
        0: begin wp = 80; rp = 30; end
        1: begin wp = 30; rp = 80; end
        default: begin wp = 50; rp = 50; end
      endcase
      wen_n = ($urandom % 100) >= wp;
      ren_n = ($urandom % 100) >= rp;
      rcs_n = ($urandom % 100) >= 85;
      wcs_n = ($urandom % 100) >= 90;
      oe_n  = ($urandom % 100) >= 90;
      wdata = DW'($urandom);
      step();
    end
  endtask

  initial begin
    int seed_ret;
    seed_ret = $urandom(32'd7351);
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        do_reset(m[0], s);
        directed();
        random_run(1200);
      end
    end
    report();
  end

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog (run did not complete): actual hung expected done");
    report();
  end

endmodule